// File: doc/BRIEF.md
# DS1 Dejitter Elastic Buffer

This block takes one DS1 bit stream that arrives gapped and jittered from a DS3-to-DS1 demultiplexer and sends it out again as an evenly paced stream. Each output bit comes with a one-cycle enable strobe, and the strobes arrive near 1.544 MHz on average. The block runs in the 44.736 MHz reference domain. Two reference tick inputs mark the reference edges: one for the primary reference and one for the fallback (transmit) reference. A 24-bit phase accumulator adds its increment on each selected tick, and every carry out of the accumulator reads one bit from a 64-bit elastic store. The fill level of the store trims the increment, so the read rate follows the average write rate.

The smoothed path is active only when the enable bit of the control register is set and the force-bypass input is low. In every other case the selected input goes straight to the output with one register of delay. The store recentres itself when any of these occurs: the hardware reset, a software reset pulse, a write into a full store, or a read from an empty store. The last two are automatic, and they set a sticky flag that stays set until software clears it. The stream that enters the store is either the demultiplexed receive data or the looped-back data, chosen by a select input.

Top module: `ds1_dejitter`

## Requirements
- R1: When the block is bypassed, each input strobe and its bit appear on out_en/out_data exactly one clock later, and the store emits no bits.
- R2: A high bypass_force selects the bypass path even when the enable bit is 1.
- R3: A cfg_wr at cfg_addr 0x3D loads the enable bit from cfg_wdata bit 7. Data bits 6..0 and writes to any other address have no effect. The enable bit is 0 after the hardware reset.
- R4: The accumulator advances on prim_tick while clk_fail is 0 and loop_time is 0. It advances on fb_tick when clk_fail is 1 or loop_time is 1, and in that case prim_tick is ignored.
- R5: Each selected tick adds 579042 + clamp(fill − 32, ±115) to the 24-bit phase. Each carry out reads one bit. Starting from a fill of 32 and phase 0 with no writes, 290 selected ticks produce exactly 10 output bits.
- R6: After any reset the fill is 32 and the phase is 0. After the hardware reset the 32 preloaded bits are 0 and are read out before any newly written bit.
- R7: A write into a full store (fill 64) with no read in the same cycle recentres the store and sets self_rst_seen.
- R8: A read from an empty store recentres the store, produces no output strobe, and sets self_rst_seen.
- R9: self_rst_seen stays at 1 until sticky_clr is pulsed, and then reads 0.
- R10: In bypass, writes to the store and overflow/underflow detection are suppressed, so the fill is unchanged and self_rst_seen stays 0.
- R11: With lpbk_sel = 1 the store takes lpbk_data/lpbk_en and ignores rx_data/rx_en.
- R12: A write and a read in the same cycle at fill 64 is not an overflow. The fill stays at 64 and one bit is emitted.
- R13: A sw_rst pulse recentres the store without changing the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| prim_tick | input | 1 | Primary reference edge marker |
| fb_tick | input | 1 | Fallback (transmit) reference edge marker |
| clk_fail | input | 1 | Primary reference lost |
| loop_time | input | 1 | Loop-timing mode, uses the fallback reference |
| bypass_force | input | 1 | Forces the bypass path |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| sw_rst | input | 1 | Software reset pulse for the buffer |
| rx_data | input | 1 | Demultiplexed receive bit |
| rx_en | input | 1 | Receive bit strobe |
| lpbk_sel | input | 1 | Selects the looped-back stream |
| lpbk_data | input | 1 | Looped-back bit |
| lpbk_en | input | 1 | Looped-back bit strobe |
| sticky_clr | input | 1 | Clears the self-reset flag |
| out_data | output | 1 | Output bit |
| out_en | output | 1 | Output bit strobe |
| self_rst_seen | output | 1 | Sticky flag for an automatic self-reset |

## Verification
A write strobe and an accumulator carry can land in the same cycle while the store is full. This case separates a true overflow from a simultaneous read and write. The bench fills the store to 64 bits with the ticks held off, then gives exactly 28 selected ticks so that the phase sits just below the carry. The 29th tick is driven in the same cycle as one more write. The result passes if one bit comes out and the sticky flag stays clear. A single write afterwards, with no tick, must then set the flag.

// File: rtl/djb_pkg.sv
package djb_pkg;

   typedef enum logic {
      REF_PRIMARY  = 1'b0,
      REF_FALLBACK = 1'b1
   } ref_src_e;

   function automatic int clamp_sym(input int v, input int lim);
      if (v > lim)
         return lim;
      else if (v < -lim)
         return -lim;
      else
         return v;
   endfunction

endpackage

// File: rtl/djb_ref_sel.sv
module djb_ref_sel
   import djb_pkg::*;
(
   input  logic     prim_tick,
   input  logic     fb_tick,
   input  logic     clk_fail,
   input  logic     loop_time,
   output ref_src_e src,
   output logic     ref_tick
);

   always_comb begin
      src      = (clk_fail || loop_time) ? REF_FALLBACK : REF_PRIMARY;
      ref_tick = (src == REF_FALLBACK) ? fb_tick : prim_tick;
   end

endmodule

// File: rtl/djb_fifo.sv
module djb_fifo #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1,
   localparam int HALF = DEPTH / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic          wdata,
   input  logic          rd,
   output logic          rdata,
   output logic [LW-1:0] level,
   output logic          ovf,
   output logic          unf
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("djb_fifo: DEPTH must be a power of two of at least 4");
   end

   logic [DEPTH-1:0] mem;
   logic [AW-1:0]    wptr, rptr;
   logic             wr_ok, rd_ok;

   always_comb begin
      ovf   = wr && !rd && (level == LW'(DEPTH));
      unf   = rd && (level == '0);
      wr_ok = wr && !ovf && !unf;
      rd_ok = rd && !unf;
      rdata = mem[rptr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= AW'(HALF);
         rptr  <= '0;
         level <= LW'(HALF);
      end else if (clr || ovf || unf) begin
         wptr  <= AW'(HALF);
         rptr  <= '0;
         level <= LW'(HALF);
      end else begin
         if (wr_ok)
            wptr <= wptr + 1'b1;
         if (rd_ok)
            rptr <= rptr + 1'b1;
         if (wr_ok && !rd_ok)
            level <= level + 1'b1;
         else if (rd_ok && !wr_ok)
            level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem <= '0;
      else if (wr_ok && !clr)
         mem[wptr] <= wdata;
   end

   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= LW'(DEPTH)));

   assert_recentre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || ovf || unf) |=> (level == LW'(HALF)));

endmodule

// File: rtl/djb_nco.sv
module djb_nco
   import djb_pkg::*;
#(
   parameter int ACC_W     = 24,
   parameter int NOM_INC   = 579042,
   parameter int PPM_LIMIT = 200,
   parameter int LW        = 7,
   parameter int HALF      = 32,
   localparam int TRIM_MAX = NOM_INC * PPM_LIMIT / 1000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [LW-1:0] level,
   output logic          strobe
);

   if (TRIM_MAX < 1 || NOM_INC + TRIM_MAX >= (1 << (ACC_W - 1))) begin : g_bad_inc
      $error("djb_nco: increment or trim range does not fit the accumulator");
   end

   logic [ACC_W-1:0] phase;
   logic [ACC_W-1:0] inc;
   logic [ACC_W:0]   sum;
   int               trim;

   always_comb begin
      trim   = clamp_sym(int'(level) - HALF, TRIM_MAX);
      inc    = ACC_W'(NOM_INC + trim);
      sum    = {1'b0, phase} + {1'b0, inc};
      strobe = tick && sum[ACC_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clr)
         phase <= '0;
      else if (tick)
         phase <= sum[ACC_W-1:0];
   end

   assert_inc_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(inc) >= NOM_INC - TRIM_MAX) && (int'(inc) <= NOM_INC + TRIM_MAX));

   assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(phase));

endmodule

// File: rtl/ds1_dejitter.sv
module ds1_dejitter
   import djb_pkg::*;
#(
   parameter int         DEPTH        = 64,
   parameter int         ACC_W        = 24,
   parameter int         NOM_INC      = 579042,
   parameter int         PPM_LIMIT    = 200,
   parameter logic [7:0] CFG_ADDR     = 8'h3D,
   parameter int         EN_BIT       = 7,
   parameter bit         HAS_LOOPBACK = 1'b1,
   localparam int        LW           = $clog2(DEPTH) + 1,
   localparam int        HALF         = DEPTH / 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prim_tick,
   input  logic       fb_tick,
   input  logic       clk_fail,
   input  logic       loop_time,
   input  logic       bypass_force,
   input  logic       cfg_wr,
   input  logic [7:0] cfg_addr,
   input  logic [7:0] cfg_wdata,
   input  logic       sw_rst,
   input  logic       rx_data,
   input  logic       rx_en,
   input  logic       lpbk_sel,
   input  logic       lpbk_data,
   input  logic       lpbk_en,
   input  logic       sticky_clr,
   output logic       out_data,
   output logic       out_en,
   output logic       self_rst_seen
);

   if (EN_BIT < 0 || EN_BIT > 7) begin : g_bad_bit
      $error("ds1_dejitter: EN_BIT must lie within the 8-bit register");
   end

   logic          dj_enable;
   logic          bypass;
   logic          sel_data, sel_en;
   ref_src_e      src;
   logic          ref_tick;
   logic          strobe;
   logic          fifo_wr, fifo_rd, fifo_rdata;
   logic [LW-1:0] level;
   logic          ovf, unf, auto_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dj_enable <= 1'b0;
      else if (cfg_wr && cfg_addr == CFG_ADDR)
         dj_enable <= cfg_wdata[EN_BIT];
   end

   assign bypass = bypass_force || !dj_enable;

   if (HAS_LOOPBACK) begin : g_lpbk
      assign sel_data = lpbk_sel ? lpbk_data : rx_data;
      assign sel_en   = lpbk_sel ? lpbk_en   : rx_en;
   end else begin : g_rx_only
      logic unused_lpbk;
      assign unused_lpbk = lpbk_sel ^ lpbk_data ^ lpbk_en;
      assign sel_data    = rx_data;
      assign sel_en      = rx_en;
   end

   djb_ref_sel u_ref (
      .prim_tick (prim_tick),
      .fb_tick   (fb_tick),
      .clk_fail  (clk_fail),
      .loop_time (loop_time),
      .src       (src),
      .ref_tick  (ref_tick)
   );

   assign fifo_wr  = sel_en && !bypass;
   assign fifo_rd  = strobe && !bypass;
   assign auto_rst = ovf || unf;

   djb_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sw_rst),
      .wr    (fifo_wr),
      .wdata (sel_data),
      .rd    (fifo_rd),
      .rdata (fifo_rdata),
      .level (level),
      .ovf   (ovf),
      .unf   (unf)
   );

   djb_nco #(
      .ACC_W     (ACC_W),
      .NOM_INC   (NOM_INC),
      .PPM_LIMIT (PPM_LIMIT),
      .LW        (LW),
      .HALF      (HALF)
   ) u_nco (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sw_rst || auto_rst),
      .tick   (ref_tick),
      .level  (level),
      .strobe (strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en   <= 1'b0;
         out_data <= 1'b0;
      end else if (bypass) begin
         out_en   <= sel_en;
         out_data <= sel_data;
      end else begin
         out_en   <= fifo_rd && !unf && !sw_rst;
         out_data <= fifo_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         self_rst_seen <= 1'b0;
      else if (auto_rst)
         self_rst_seen <= 1'b1;
      else if (sticky_clr)
         self_rst_seen <= 1'b0;
   end

   assert_bypass_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (out_en == $past(sel_en)));

   assert_bypass_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && !sw_rst) |=> $stable(level));

   assert_auto_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf || unf) |=> self_rst_seen);

   assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (self_rst_seen && !sticky_clr) |=> self_rst_seen);

endmodule

// File: tb/test_ds1_dejitter.sv
module test_ds1_dejitter;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prim_tick = 0, fb_tick = 0, clk_fail = 0, loop_time = 0, bypass_force = 0;
   logic cfg_wr = 0;
   logic [7:0] cfg_addr = '0, cfg_wdata = '0;
   logic sw_rst = 0, rx_data = 0, rx_en = 0, lpbk_sel = 0, lpbk_data = 0, lpbk_en = 0;
   logic sticky_clr = 0;
   logic out_data, out_en, self_rst_seen;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   bit cap[$];

   always #2.5 clk = ~clk;

   ds1_dejitter i_ds1_dejitter (
      .clk(clk), .rst_n(rst_n), .prim_tick(prim_tick), .fb_tick(fb_tick),
      .clk_fail(clk_fail), .loop_time(loop_time), .bypass_force(bypass_force),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sw_rst(sw_rst),
      .rx_data(rx_data), .rx_en(rx_en), .lpbk_sel(lpbk_sel), .lpbk_data(lpbk_data),
      .lpbk_en(lpbk_en), .sticky_clr(sticky_clr), .out_data(out_data),
      .out_en(out_en), .self_rst_seen(self_rst_seen)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      if (out_en) cap.push_back(out_data);
   endtask

   task automatic hw_reset();
      rst_n = 0; prim_tick = 0; fb_tick = 0; clk_fail = 0; loop_time = 0;
      bypass_force = 0; rx_en = 0; lpbk_en = 0; lpbk_sel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      cap.delete();
   endtask

   task automatic cfg(input logic [7:0] a, input logic [7:0] d);
      cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      cyc();
      cfg_wr = 0;
   endtask

   task automatic soft_reset();
      sw_rst = 1; cyc(); sw_rst = 0; cyc();
      cap.delete();
   endtask

   task automatic send_rx(input logic [15:0] pat, input int n);
      for (int i = 0; i < n; i++) begin
         rx_en = 1; rx_data = pat[i]; cyc();
      end
      rx_en = 0; cyc();
   endtask

   task automatic t_reset_state();
      hw_reset();
      chk(out_en == 0 && self_rst_seen == 0, "R6 reset outputs", int'(out_en) + int'(self_rst_seen), 0);
   endtask

   task automatic t_cfg_decode();
      hw_reset();
      cfg(8'h3C, 8'h80); send_rx(16'h1, 1);
      chk(cap.size() == 1, "R3 other address ignored", cap.size(), 1);
      cap.delete(); cfg(8'h3D, 8'h7F); send_rx(16'h1, 1);
      chk(cap.size() == 1, "R3 low bits ignored", cap.size(), 1);
      cap.delete(); cfg(8'h3D, 8'h80); send_rx(16'h1, 1); cyc();
      chk(cap.size() == 0, "R3 bit7 enables buffer", cap.size(), 0);
      cap.delete(); soft_reset(); send_rx(16'h1, 1);
      chk(cap.size() == 0, "R13 sw reset keeps enable", cap.size(), 0);
      cap.delete(); cfg(8'h3D, 8'h00); send_rx(16'h1, 1);
      chk(cap.size() == 1, "R3 bit7 clear disables", cap.size(), 1);
   endtask

   task automatic t_bypass();
      logic [15:0] pat = 16'hB4E1;
      int ok = 1;
      hw_reset();
      prim_tick = 1;
      send_rx(pat, 16);
      repeat (1500) cyc();
      prim_tick = 0;
      chk(cap.size() == 16, "R1 bypass count", cap.size(), 16);
      for (int i = 0; i < 16 && i < cap.size(); i++) if (cap[i] != pat[i]) ok = 0;
      chk(ok == 1, "R1 bypass data", ok, 1);
      chk(self_rst_seen == 0, "R10 no self reset in bypass", int'(self_rst_seen), 0);
      cfg(8'h3D, 8'h80); cap.delete();
      for (int k = 0; k < 2000 && !self_rst_seen; k++) begin prim_tick = 1; cyc(); end
      prim_tick = 0;
      chk(cap.size() == 32, "R10 fill unchanged by bypass writes", cap.size(), 32);
   endtask

   task automatic t_force();
      logic [15:0] pat = 16'h00A5;
      int ok = 1;
      hw_reset(); cfg(8'h3D, 8'h80);
      bypass_force = 1; cap.delete();
      send_rx(pat, 8);
      bypass_force = 0;
      chk(cap.size() == 8, "R2 force bypass count", cap.size(), 8);
      for (int i = 0; i < 8 && i < cap.size(); i++) if (cap[i] != pat[i]) ok = 0;
      chk(ok == 1, "R2 force bypass data", ok, 1);
   endtask

   task automatic t_data_path();
      logic [15:0] pat = 16'hC3A9;
      int ok0 = 1, okp = 1;
      hw_reset(); cfg(8'h3D, 8'h80);
      send_rx(pat, 16); cap.delete();
      for (int k = 0; k < 3000; k++) begin
         cyc();
         if (cap.size() >= 48) break;
         prim_tick = 1;
      end
      prim_tick = 0;
      chk(cap.size() == 48, "R6 output count", cap.size(), 48);
      for (int i = 0; i < 32 && i < cap.size(); i++) if (cap[i] != 0) ok0 = 0;
      chk(ok0 == 1, "R6 zero preload first", ok0, 1);
      for (int i = 0; i < 16 && 32 + i < cap.size(); i++) if (cap[32+i] != pat[i]) okp = 0;
      chk(okp == 1, "R6 written bits follow", okp, 1);
   endtask

   task automatic t_loopback();
      logic [15:0] pat = 16'h005B;
      int ok = 1;
      hw_reset(); cfg(8'h3D, 8'h80);
      soft_reset();
      lpbk_sel = 1;
      for (int i = 0; i < 8; i++) begin
         lpbk_en = 1; lpbk_data = pat[i]; rx_en = 1; rx_data = ~pat[i]; cyc();
      end
      lpbk_en = 0; rx_en = 0; cyc(); cap.delete();
      for (int k = 0; k < 3000; k++) begin
         cyc();
         if (cap.size() >= 40) break;
         prim_tick = 1;
      end
      prim_tick = 0; lpbk_sel = 0;
      chk(cap.size() == 40, "R11 loopback count", cap.size(), 40);
      for (int i = 0; i < 8 && 32 + i < cap.size(); i++) if (cap[32+i] != pat[i]) ok = 0;
      chk(ok == 1, "R11 loopback data", ok, 1);
   endtask

   task automatic rate_run(input bit use_fb, input int exp, input string req);
      soft_reset();
      for (int k = 0; k < 290; k++) begin
         if (use_fb) fb_tick = 1; else prim_tick = 1;
         cyc();
      end
      prim_tick = 0; fb_tick = 0; cyc(); cyc();
      chk(cap.size() == exp, req, cap.size(), exp);
   endtask

   task automatic t_ref_rate();
      hw_reset(); cfg(8'h3D, 8'h80);
      rate_run(0, 10, "R5 primary rate 10 per 290 ticks");
      rate_run(1, 0, "R4 fallback tick ignored normally");
      clk_fail = 1;
      rate_run(0, 0, "R4 primary ignored on failure");
      rate_run(1, 10, "R4 fallback used on failure");
      clk_fail = 0; loop_time = 1;
      rate_run(0, 0, "R4 primary ignored in loop timing");
      rate_run(1, 10, "R4 fallback used in loop timing");
      loop_time = 0;
   endtask

   task automatic t_underflow();
      hw_reset(); cfg(8'h3D, 8'h80);
      for (int k = 0; k < 2000 && !self_rst_seen; k++) begin prim_tick = 1; cyc(); end
      prim_tick = 0;
      chk(self_rst_seen == 1, "R8 underflow sets flag", int'(self_rst_seen), 1);
      chk(cap.size() == 32, "R8 bits before underflow", cap.size(), 32);
   endtask

   task automatic t_overflow();
      hw_reset(); cfg(8'h3D, 8'h80);
      send_rx(16'hFFFF, 16); send_rx(16'hFFFF, 16);
      chk(self_rst_seen == 0, "R7 full without overflow", int'(self_rst_seen), 0);
      for (int k = 0; k < 28; k++) begin prim_tick = 1; cyc(); end
      chk(cap.size() == 0, "R12 no carry before 29th tick", cap.size(), 0);
      rx_en = 1; rx_data = 1; cyc();
      prim_tick = 0; rx_en = 0; cyc();
      chk(cap.size() == 1, "R12 read at full emits bit", cap.size(), 1);
      chk(self_rst_seen == 0, "R12 simultaneous rd/wr no overflow", int'(self_rst_seen), 0);
      rx_en = 1; cyc(); rx_en = 0; cyc();
      chk(self_rst_seen == 1, "R7 overflow sets flag", int'(self_rst_seen), 1);
      repeat (20) cyc();
      chk(self_rst_seen == 1, "R9 flag holds", int'(self_rst_seen), 1);
      sticky_clr = 1; cyc(); sticky_clr = 0; cyc();
      chk(self_rst_seen == 0, "R9 clear drops flag", int'(self_rst_seen), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_cfg_decode();
      t_bypass();
      t_force();
      t_data_path();
      t_loopback();
      t_ref_rate();
      t_underflow();
      t_overflow();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule